// File: doc/BRIEF.md
# Split Instruction/Data Page Translation Unit

The block turns 32-bit virtual addresses into physical addresses with 8 KiB pages. It holds two direct-mapped lookaside tables, one for instruction fetches and one for data loads and stores. Each table entry has a match word and a translate word. The match word carries the page tag and a valid flag. The translate word carries the page frame and six permission bits, split into supervisor and user sets. Entries are loaded one word at a time through a single indexed write port.

A lookup combines the address, the access kind and the privilege mode, and returns three results in the same cycle: the physical address, the rights granted in that mode, and a status of hit, miss or permission fault. When a valid lookup fails, the block registers an exception cause that tells fetch from data and miss from fault. It also captures the failing address and cancels any load-linked reservation.

A separate debug port translates any address with no side effects. It tries the data table first, then the instruction table, then falls back to identity mapping. When the enable input is low, every access passes through untranslated with full rights.

Top module: `tlb_xlate_unit`

## Requirements
- R1: After synchronous reset every entry of both tables is invalid, so any lookup with translation enabled reports miss (status 1). No exception is pending, the captured address is zero and no reservation is held.
- R2: The set is chosen by the low bits of the virtual page number (address bits 18:13 with 64 sets). The table is the instruction table for access kind 2 and the data table for kinds 0 and 1. A hit needs match word bits 31:13 equal to the full page number and match word bit 0 set. Otherwise the status is 1, the rights are 0 and the physical address output is 0.
- R3: A write selects the instruction table when its table-select input is 1 and the data table when it is 0. It writes the translate word when its word-select input is 1 and the match word when it is 0. A lookup in the cycle of the write sees the old contents, and a lookup in the next cycle sees the new ones.
- R4: For a fetch (kind 2), execute right comes from translate bit 2 in supervisor mode and from bit 5 in user mode. The rights output is {exec, write, read}, with write and read both 0.
- R5: For a load (kind 0) or a store (kind 1), read and write rights come from translate bits 0 and 1 in supervisor mode and from bits 3 and 4 in user mode. The exec right reads as 0.
- R6: A matching entry gives status 2 (permission fault) in three cases: a load without read right, a store without write right, or a fetch without execute right. The granted rights are still shown.
- R7: On a hit the physical address is translate word bits 31:13 followed by virtual address bits 12:0.
- R8: A failed lookup with its valid input high and translation enabled raises an exception one clock later, which lasts one cycle. The cause is 0 for an instruction miss, 1 for a data miss, 2 for an instruction permission fault and 3 for a data permission fault.
- R9: The captured-address register takes the failing virtual address on the edge that raises the exception. It holds its value at all other times.
- R10: A reservation request makes the reservation valid with its address on the next edge. A fault clears the reservation, and the fault wins when a request arrives in the same cycle.
- R11: With the enable input low, every lookup hits, the physical address equals the virtual address, the rights are 3'b111 and no exception is raised.
- R12: A debug lookup in the current mode uses the data table if it hits with read right (source 0). Otherwise it uses the instruction table if that hits with execute right (source 1). Otherwise it gives an identity result (source 2, physical equals virtual). With translation disabled the result is always identity with source 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmu_en_i | input | 1 | Translation enable |
| sup_mode_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| wr_en_i | input | 1 | Table write strobe |
| wr_itlb_i | input | 1 | 1 = instruction table, 0 = data table |
| wr_xlat_i | input | 1 | 1 = translate word, 0 = match word |
| wr_idx_i | input | 6 | Entry index to write |
| wr_data_i | input | 32 | Word to write |
| lk_valid_i | input | 1 | Lookup is a real access (enables exception) |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_type_i | input | 2 | 0 load, 1 store, 2 fetch |
| lk_paddr_o | output | 32 | Physical address |
| lk_rights_o | output | 3 | Granted rights {exec, write, read} |
| lk_status_o | output | 2 | 0 hit, 1 miss, 2 permission fault |
| exc_valid_o | output | 1 | Exception pulse |
| exc_cause_o | output | 2 | Exception cause code |
| eear_o | output | 32 | Captured failing address |
| llres_set_i | input | 1 | Establish a load-linked reservation |
| llres_addr_i | input | 32 | Reservation address |
| llres_valid_o | output | 1 | Reservation held |
| llres_addr_o | output | 32 | Reservation address |
| dbg_vaddr_i | input | 32 | Debug lookup address |
| dbg_paddr_o | output | 32 | Debug physical address |
| dbg_src_o | output | 2 | Debug result source: 0 data, 1 instruction, 2 identity |

## Verification
A table write and a lookup of the same entry can fall in the same cycle. The bench provokes this on purpose by rewriting a data translate word to add user write right while a user store probes that same entry. The reference model applies writes only after it evaluates the lookup, so it expects the old permission fault in that cycle and a hit in the next. A second collision pairs a reservation request with a faulting lookup. The model expects the reservation cleared, not set, and this case recurs many times in the random phase.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned PG_OFS = 13;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        XS_HIT  = 2'd0,
        XS_MISS = 2'd1,
        XS_PERM = 2'd2,
        XS_RSVD = 2'd3
    } xstat_e;

    typedef enum logic [1:0] {
        EX_IMISS  = 2'd0,
        EX_DMISS  = 2'd1,
        EX_IFAULT = 2'd2,
        EX_DFAULT = 2'd3
    } excc_e;

    // translate word low six bits, MSB first
    typedef struct packed {
        logic ux;
        logic uw;
        logic ur;
        logic sx;
        logic sw;
        logic sr;
    } perm_t;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    function automatic rights_t mode_rights(perm_t p, logic sup, logic fetch);
        rights_t g;
        g = '0;
        if (fetch) begin
            g.x = sup ? p.sx : p.ux;
        end else begin
            g.w = sup ? p.sw : p.uw;
            g.r = sup ? p.sr : p.ur;
        end
        return g;
    endfunction

    function automatic logic access_ok(rights_t g, acc_e a);
        case (a)
            ACC_FETCH: return g.x;
            ACC_STORE: return g.w;
            default:   return g.r;
        endcase
    endfunction

    function automatic excc_e fault_cause(logic fetch, logic perm);
        if (fetch) return perm ? EX_IFAULT : EX_IMISS;
        return perm ? EX_DFAULT : EX_DMISS;
    endfunction

endpackage

// File: rtl/tlb_array.sv
module tlb_array import tlb_pkg::*; #(
    parameter int unsigned AW   = XLEN,
    parameter int unsigned PB   = PG_OFS,
    parameter int unsigned SETS = 64,
    localparam int unsigned IW  = $clog2(SETS),
    localparam int unsigned VW  = AW - PB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          wxlat,
    input  logic [IW-1:0] widx,
    input  logic [VW-1:0] whi,
    input  perm_t         wlo,
    input  logic [IW-1:0] ra_idx,
    output logic [VW-1:0] ra_tag,
    output logic          ra_vld,
    output logic [VW-1:0] ra_ppn,
    output perm_t         ra_perm,
    input  logic [IW-1:0] rb_idx,
    output logic [VW-1:0] rb_tag,
    output logic          rb_vld,
    output logic [VW-1:0] rb_ppn,
    output perm_t         rb_perm
);

    logic [VW-1:0] tag_q  [SETS];
    logic          vld_q  [SETS];
    logic [VW-1:0] ppn_q  [SETS];
    perm_t         perm_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(SETS); i++) begin
                tag_q[i]  <= '0;
                vld_q[i]  <= 1'b0;
                ppn_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else if (we) begin
            if (wxlat) begin
                ppn_q[widx]  <= whi;
                perm_q[widx] <= wlo;
            end else begin
                tag_q[widx]  <= whi;
                vld_q[widx]  <= wlo.sr;
            end
        end
    end

    assign ra_tag  = tag_q[ra_idx];
    assign ra_vld  = vld_q[ra_idx];
    assign ra_ppn  = ppn_q[ra_idx];
    assign ra_perm = perm_q[ra_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rb_vld  = vld_q[rb_idx];
    assign rb_ppn  = ppn_q[rb_idx];
    assign rb_perm = perm_q[rb_idx];

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe import tlb_pkg::*; #(
    parameter int unsigned AW = XLEN,
    parameter int unsigned PB = PG_OFS,
    localparam int unsigned VW = AW - PB
) (
    input  logic [AW-1:0] vaddr,
    input  logic [VW-1:0] tag,
    input  logic          vld,
    input  logic [VW-1:0] ppn,
    input  perm_t         perm,
    input  acc_e          acc,
    input  logic          sup,
    output xstat_e        status,
    output rights_t       rights,
    output logic [AW-1:0] paddr
);

    rights_t grant;

    always_comb begin
        grant = mode_rights(perm, sup, acc == ACC_FETCH);
        paddr = {ppn, vaddr[PB-1:0]};
        if ((tag != vaddr[AW-1:PB]) || !vld) begin
            status = XS_MISS;
            rights = '0;
        end else begin
            rights = grant;
            status = access_ok(grant, acc) ? XS_HIT : XS_PERM;
        end
    end

endmodule

// File: rtl/tlb_fault_latch.sv
module tlb_fault_latch import tlb_pkg::*; #(
    parameter int unsigned AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fault_i,
    input  logic          fetch_i,
    input  logic          perm_i,
    input  logic [AW-1:0] vaddr_i,
    input  logic          ll_set_i,
    input  logic [AW-1:0] ll_addr_i,
    output logic          exc_valid_o,
    output excc_e         exc_cause_o,
    output logic [AW-1:0] eear_o,
    output logic          ll_valid_o,
    output logic [AW-1:0] ll_addr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid_o <= 1'b0;
            exc_cause_o <= EX_IMISS;
            eear_o      <= '0;
            ll_valid_o  <= 1'b0;
            ll_addr_o   <= '0;
        end else begin
            exc_valid_o <= fault_i;
            if (fault_i) begin
                exc_cause_o <= fault_cause(fetch_i, perm_i);
                eear_o      <= vaddr_i;
                ll_valid_o  <= 1'b0;
            end else if (ll_set_i) begin
                ll_valid_o  <= 1'b1;
                ll_addr_o   <= ll_addr_i;
            end
        end
    end

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit import tlb_pkg::*; #(
    parameter int unsigned AW        = XLEN,
    parameter int unsigned PB        = PG_OFS,
    parameter int unsigned ITLB_SETS = 64,
    parameter int unsigned DTLB_SETS = 64,
    localparam int unsigned IIW = $clog2(ITLB_SETS),
    localparam int unsigned DIW = $clog2(DTLB_SETS),
    localparam int unsigned WIW = (IIW > DIW) ? IIW : DIW,
    localparam int unsigned VW  = AW - PB
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mmu_en_i,
    input  logic           sup_mode_i,
    input  logic           wr_en_i,
    input  logic           wr_itlb_i,
    input  logic           wr_xlat_i,
    input  logic [WIW-1:0] wr_idx_i,
    input  logic [AW-1:0]  wr_data_i,
    input  logic           lk_valid_i,
    input  logic [AW-1:0]  lk_vaddr_i,
    input  logic [1:0]     lk_type_i,
    output logic [AW-1:0]  lk_paddr_o,
    output logic [2:0]     lk_rights_o,
    output logic [1:0]     lk_status_o,
    output logic           exc_valid_o,
    output logic [1:0]     exc_cause_o,
    output logic [AW-1:0]  eear_o,
    input  logic           llres_set_i,
    input  logic [AW-1:0]  llres_addr_i,
    output logic           llres_valid_o,
    output logic [AW-1:0]  llres_addr_o,
    input  logic [AW-1:0]  dbg_vaddr_i,
    output logic [AW-1:0]  dbg_paddr_o,
    output logic [1:0]     dbg_src_o
);

    // write-word fields; bits between the rights and the page offset are reserved
    logic [VW-1:0] wr_hi;
    perm_t         wr_lo;
    logic          unused_wr_bits;
    assign wr_hi          = wr_data_i[AW-1:PB];
    assign wr_lo          = perm_t'(wr_data_i[5:0]);
    assign unused_wr_bits = ^wr_data_i[PB-1:6];

    acc_e lk_acc;
    logic lk_fetch;
    assign lk_acc   = acc_e'(lk_type_i);
    assign lk_fetch = (lk_acc == ACC_FETCH);

    // instruction table
    logic [VW-1:0] i_ra_tag, i_ra_ppn, i_rb_tag, i_rb_ppn;
    logic          i_ra_vld, i_rb_vld;
    perm_t         i_ra_perm, i_rb_perm;

    tlb_array #(.AW(AW), .PB(PB), .SETS(ITLB_SETS)) u_itlb (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en_i & wr_itlb_i),
        .wxlat   (wr_xlat_i),
        .widx    (wr_idx_i[IIW-1:0]),
        .whi     (wr_hi),
        .wlo     (wr_lo),
        .ra_idx  (lk_vaddr_i[PB +: IIW]),
        .ra_tag  (i_ra_tag),
        .ra_vld  (i_ra_vld),
        .ra_ppn  (i_ra_ppn),
        .ra_perm (i_ra_perm),
        .rb_idx  (dbg_vaddr_i[PB +: IIW]),
        .rb_tag  (i_rb_tag),
        .rb_vld  (i_rb_vld),
        .rb_ppn  (i_rb_ppn),
        .rb_perm (i_rb_perm)
    );

    // data table
    logic [VW-1:0] d_ra_tag, d_ra_ppn, d_rb_tag, d_rb_ppn;
    logic          d_ra_vld, d_rb_vld;
    perm_t         d_ra_perm, d_rb_perm;

    tlb_array #(.AW(AW), .PB(PB), .SETS(DTLB_SETS)) u_dtlb (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en_i & ~wr_itlb_i),
        .wxlat   (wr_xlat_i),
        .widx    (wr_idx_i[DIW-1:0]),
        .whi     (wr_hi),
        .wlo     (wr_lo),
        .ra_idx  (lk_vaddr_i[PB +: DIW]),
        .ra_tag  (d_ra_tag),
        .ra_vld  (d_ra_vld),
        .ra_ppn  (d_ra_ppn),
        .ra_perm (d_ra_perm),
        .rb_idx  (dbg_vaddr_i[PB +: DIW]),
        .rb_tag  (d_rb_tag),
        .rb_vld  (d_rb_vld),
        .rb_ppn  (d_rb_ppn),
        .rb_perm (d_rb_perm)
    );

    // main lookup: the access kind selects the table
    xstat_e        lk_st;
    rights_t       lk_rt;
    logic [AW-1:0] lk_pa;

    tlb_probe #(.AW(AW), .PB(PB)) u_lk_probe (
        .vaddr  (lk_vaddr_i),
        .tag    (lk_fetch ? i_ra_tag  : d_ra_tag),
        .vld    (lk_fetch ? i_ra_vld  : d_ra_vld),
        .ppn    (lk_fetch ? i_ra_ppn  : d_ra_ppn),
        .perm   (lk_fetch ? i_ra_perm : d_ra_perm),
        .acc    (lk_acc),
        .sup    (sup_mode_i),
        .status (lk_st),
        .rights (lk_rt),
        .paddr  (lk_pa)
    );

    always_comb begin
        if (!mmu_en_i) begin
            lk_status_o = XS_HIT;
            lk_rights_o = 3'b111;
            lk_paddr_o  = lk_vaddr_i;
        end else begin
            lk_status_o = lk_st;
            lk_rights_o = lk_rt;
            lk_paddr_o  = (lk_st == XS_HIT) ? lk_pa : '0;
        end
    end

    // fault capture
    logic  lk_fault;
    excc_e cause_q;
    assign lk_fault = lk_valid_i & mmu_en_i & (lk_st != XS_HIT);

    tlb_fault_latch #(.AW(AW)) u_fault (
        .clk         (clk),
        .rst         (rst),
        .fault_i     (lk_fault),
        .fetch_i     (lk_fetch),
        .perm_i      (lk_st == XS_PERM),
        .vaddr_i     (lk_vaddr_i),
        .ll_set_i    (llres_set_i),
        .ll_addr_i   (llres_addr_i),
        .exc_valid_o (exc_valid_o),
        .exc_cause_o (cause_q),
        .eear_o      (eear_o),
        .ll_valid_o  (llres_valid_o),
        .ll_addr_o   (llres_addr_o)
    );
    assign exc_cause_o = cause_q;

    // debug lookup: data table, then instruction table, then identity
    xstat_e        dd_st, di_st;
    rights_t       dd_rt, di_rt;
    logic [AW-1:0] dd_pa, di_pa;
    logic          unused_dbg_rights;
    assign unused_dbg_rights = ^{dd_rt, di_rt};

    tlb_probe #(.AW(AW), .PB(PB)) u_dbg_dprobe (
        .vaddr  (dbg_vaddr_i),
        .tag    (d_rb_tag),
        .vld    (d_rb_vld),
        .ppn    (d_rb_ppn),
        .perm   (d_rb_perm),
        .acc    (ACC_LOAD),
        .sup    (sup_mode_i),
        .status (dd_st),
        .rights (dd_rt),
        .paddr  (dd_pa)
    );

    tlb_probe #(.AW(AW), .PB(PB)) u_dbg_iprobe (
        .vaddr  (dbg_vaddr_i),
        .tag    (i_rb_tag),
        .vld    (i_rb_vld),
        .ppn    (i_rb_ppn),
        .perm   (i_rb_perm),
        .acc    (ACC_FETCH),
        .sup    (sup_mode_i),
        .status (di_st),
        .rights (di_rt),
        .paddr  (di_pa)
    );

    always_comb begin
        if (mmu_en_i && dd_st == XS_HIT) begin
            dbg_src_o   = 2'd0;
            dbg_paddr_o = dd_pa;
        end else if (mmu_en_i && di_st == XS_HIT) begin
            dbg_src_o   = 2'd1;
            dbg_paddr_o = di_pa;
        end else begin
            dbg_src_o   = 2'd2;
            dbg_paddr_o = dbg_vaddr_i;
        end
    end

endmodule

// File: rtl/tlb_xlate_unit_chk.sv
module tlb_xlate_unit_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned PB = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          mmu_en_i,
    input logic          lk_valid_i,
    input logic [AW-1:0] lk_vaddr_i,
    input logic [1:0]    lk_type_i,
    input logic [AW-1:0] lk_paddr_o,
    input logic [2:0]    lk_rights_o,
    input logic [1:0]    lk_status_o,
    input logic          exc_valid_o,
    input logic [AW-1:0] eear_o,
    input logic          llres_valid_o,
    input logic [AW-1:0] dbg_vaddr_i,
    input logic [AW-1:0] dbg_paddr_o,
    input logic [1:0]    dbg_src_o
);

    // R2
    miss_norights_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_status_o == 2'd1) |-> (lk_rights_o == 3'd0 && lk_paddr_o == '0));

    // R2
    status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        lk_status_o != 2'd3);

    // R6
    fetch_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (mmu_en_i && lk_status_o == 2'd2 && lk_type_i == 2'd2) |-> !lk_rights_o[2]);

    // R7
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_status_o == 2'd0) |-> (lk_paddr_o[PB-1:0] == lk_vaddr_i[PB-1:0]));

    // R8
    fault_raises_exc_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid_i && mmu_en_i && lk_status_o != 2'd0) |=> exc_valid_o);

    // R8
    exc_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> $past(lk_valid_i && mmu_en_i && lk_status_o != 2'd0));

    // R9
    eear_capture_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> (eear_o == $past(lk_vaddr_i)));

    // R9
    eear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_valid_o |-> $stable(eear_o));

    // R10
    llres_clear_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> !llres_valid_o);

    // R11
    identity_chk: assert property (@(posedge clk) disable iff (rst)
        !mmu_en_i |-> (lk_paddr_o == lk_vaddr_i && lk_status_o == 2'd0 && lk_rights_o == 3'b111));

    // R12
    dbg_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_src_o == 2'd2) |-> (dbg_paddr_o == dbg_vaddr_i));

endmodule

bind tlb_xlate_unit tlb_xlate_unit_chk #(.AW(AW), .PB(PB)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mmu_en_i      (mmu_en_i),
    .lk_valid_i    (lk_valid_i),
    .lk_vaddr_i    (lk_vaddr_i),
    .lk_type_i     (lk_type_i),
    .lk_paddr_o    (lk_paddr_o),
    .lk_rights_o   (lk_rights_o),
    .lk_status_o   (lk_status_o),
    .exc_valid_o   (exc_valid_o),
    .eear_o        (eear_o),
    .llres_valid_o (llres_valid_o),
    .dbg_vaddr_i   (dbg_vaddr_i),
    .dbg_paddr_o   (dbg_paddr_o),
    .dbg_src_o     (dbg_src_o)
);

// File: tb/tlb_xlate_unit_test.sv
module tlb_xlate_unit_test;

    localparam int SETS = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, mmu_en_i, sup_mode_i;
    logic        wr_en_i, wr_itlb_i, wr_xlat_i;
    logic [5:0]  wr_idx_i;
    logic [31:0] wr_data_i;
    logic        lk_valid_i;
    logic [31:0] lk_vaddr_i;
    logic [1:0]  lk_type_i;
    logic [31:0] lk_paddr_o;
    logic [2:0]  lk_rights_o;
    logic [1:0]  lk_status_o;
    logic        exc_valid_o;
    logic [1:0]  exc_cause_o;
    logic [31:0] eear_o;
    logic        llres_set_i;
    logic [31:0] llres_addr_i;
    logic        llres_valid_o;
    logic [31:0] llres_addr_o;
    logic [31:0] dbg_vaddr_i;
    logic [31:0] dbg_paddr_o;
    logic [1:0]  dbg_src_o;

    tlb_xlate_unit uut (
        .clk(clk), .rst(rst), .mmu_en_i(mmu_en_i), .sup_mode_i(sup_mode_i),
        .wr_en_i(wr_en_i), .wr_itlb_i(wr_itlb_i), .wr_xlat_i(wr_xlat_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_type_i(lk_type_i),
        .lk_paddr_o(lk_paddr_o), .lk_rights_o(lk_rights_o), .lk_status_o(lk_status_o),
        .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o), .eear_o(eear_o),
        .llres_set_i(llres_set_i), .llres_addr_i(llres_addr_i),
        .llres_valid_o(llres_valid_o), .llres_addr_o(llres_addr_o),
        .dbg_vaddr_i(dbg_vaddr_i), .dbg_paddr_o(dbg_paddr_o), .dbg_src_o(dbg_src_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic [31:0] m_imw [SETS];
    logic [31:0] m_itw [SETS];
    logic [31:0] m_dmw [SETS];
    logic [31:0] m_dtw [SETS];
    logic        m_xv;
    logic [1:0]  m_xc;
    logic [31:0] m_eear;
    logic        m_llv;
    logic [31:0] m_lla;

    task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic void probe(input logic [31:0] va, input logic [31:0] mw, input logic [31:0] tw,
                                  input logic [1:0] ty, input logic sup,
                                  output logic [1:0] st, output logic [2:0] rt);
        logic r, w, x, ok;
        r = sup ? tw[0] : tw[3];
        w = sup ? tw[1] : tw[4];
        x = sup ? tw[2] : tw[5];
        if (mw[31:13] != va[31:13] || !mw[0]) begin
            st = 2'd1; rt = 3'd0;
        end else begin
            if (ty == 2'd2) begin rt = {x, 2'b00}; ok = x; end
            else begin rt = {1'b0, w, r}; ok = (ty == 2'd1) ? w : r; end
            st = ok ? 2'd0 : 2'd2;
        end
    endfunction

    task automatic step(input string ctx);
        logic [1:0]  st, dst, e_src;
        logic [2:0]  rt, drt;
        logic [31:0] pa, dpa, mw, tw;
        int          ix, dx;
        bit          flt;
        string       ts, tr, tp;
        #1;
        ix = int'(lk_vaddr_i[18:13]);
        if (!mmu_en_i) begin
            st = 2'd0; rt = 3'b111; pa = lk_vaddr_i;
        end else begin
            mw = (lk_type_i == 2'd2) ? m_imw[ix] : m_dmw[ix];
            tw = (lk_type_i == 2'd2) ? m_itw[ix] : m_dtw[ix];
            probe(lk_vaddr_i, mw, tw, lk_type_i, sup_mode_i, st, rt);
            pa = (st == 2'd0) ? {tw[31:13], lk_vaddr_i[12:0]} : 32'd0;
        end
        ts = !mmu_en_i ? "R11" : (st == 2'd2) ? "R6" : "R2";
        tr = !mmu_en_i ? "R11" : (lk_type_i == 2'd2) ? "R4" : "R5";
        tp = !mmu_en_i ? "R11" : "R7";
        cmp({ctx, ts}, "status", 32'(lk_status_o), 32'(st));
        cmp({ctx, tr}, "rights", 32'(lk_rights_o), 32'(rt));
        cmp({ctx, tp}, "paddr", lk_paddr_o, pa);
        cmp({ctx, "R8"}, "exc_valid", 32'(exc_valid_o), 32'(m_xv));
        if (m_xv) cmp({ctx, "R8"}, "exc_cause", 32'(exc_cause_o), 32'(m_xc));
        cmp({ctx, "R9"}, "eear", eear_o, m_eear);
        cmp({ctx, "R10"}, "llres_valid", 32'(llres_valid_o), 32'(m_llv));
        if (m_llv) cmp({ctx, "R10"}, "llres_addr", llres_addr_o, m_lla);

        dx = int'(dbg_vaddr_i[18:13]);
        e_src = 2'd2; dpa = dbg_vaddr_i;
        if (mmu_en_i) begin
            probe(dbg_vaddr_i, m_dmw[dx], m_dtw[dx], 2'd0, sup_mode_i, dst, drt);
            if (dst == 2'd0) begin
                e_src = 2'd0; dpa = {m_dtw[dx][31:13], dbg_vaddr_i[12:0]};
            end else begin
                probe(dbg_vaddr_i, m_imw[dx], m_itw[dx], 2'd2, sup_mode_i, dst, drt);
                if (dst == 2'd0) begin
                    e_src = 2'd1; dpa = {m_itw[dx][31:13], dbg_vaddr_i[12:0]};
                end
            end
        end
        cmp({ctx, "R12"}, "dbg_src", 32'(dbg_src_o), 32'(e_src));
        cmp({ctx, "R12"}, "dbg_paddr", dbg_paddr_o, dpa);

        // next state: lookup used the old tables, writes land afterwards
        flt = lk_valid_i && mmu_en_i && (st != 2'd0);
        m_xv = flt;
        if (flt) begin
            m_xc   = (lk_type_i == 2'd2) ? ((st == 2'd2) ? 2'd2 : 2'd0)
                                         : ((st == 2'd2) ? 2'd3 : 2'd1);
            m_eear = lk_vaddr_i;
            m_llv  = 1'b0;
        end else if (llres_set_i) begin
            m_llv = 1'b1;
            m_lla = llres_addr_i;
        end
        if (wr_en_i) begin
            if (wr_itlb_i) begin
                if (wr_xlat_i) m_itw[wr_idx_i] = wr_data_i; else m_imw[wr_idx_i] = wr_data_i;
            end else begin
                if (wr_xlat_i) m_dtw[wr_idx_i] = wr_data_i; else m_dmw[wr_idx_i] = wr_data_i;
            end
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en_i = 1'b0; lk_valid_i = 1'b0; llres_set_i = 1'b0;
    endtask

    task automatic put(input logic itlb, input logic xl, input logic [5:0] idx, input logic [31:0] d);
        quiet();
        wr_en_i = 1'b1; wr_itlb_i = itlb; wr_xlat_i = xl; wr_idx_i = idx; wr_data_i = d;
        step("R3 ");
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] ty, input logic sup, input string ctx);
        quiet();
        lk_valid_i = 1'b1; lk_vaddr_i = va; lk_type_i = ty; sup_mode_i = sup;
        step(ctx);
    endtask

    function automatic logic [31:0] summ_unused(input int a);
        return 32'(a);
    endfunction

    localparam logic [31:0] VA_D = {19'd197, 13'h0abc};
    localparam logic [31:0] VA_I = {19'd137, 13'h0010};

    initial begin
        logic [18:0] vp;
        rst = 1'b1; mmu_en_i = 1'b1; sup_mode_i = 1'b1;
        wr_en_i = 0; wr_itlb_i = 0; wr_xlat_i = 0; wr_idx_i = 0; wr_data_i = 0;
        lk_valid_i = 0; lk_vaddr_i = 0; lk_type_i = 0;
        llres_set_i = 0; llres_addr_i = 0; dbg_vaddr_i = 32'h0000_4321;
        for (int i = 0; i < SETS; i++) begin
            m_imw[i] = 0; m_itw[i] = 0; m_dmw[i] = 0; m_dtw[i] = 0;
        end
        m_xv = 0; m_xc = 0; m_eear = 0; m_llv = 0; m_lla = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything empty after reset
        quiet(); step("R1 ");
        look(32'h0000_2000, 2'd2, 1'b1, "R1 ");
        look(32'h1234_5678, 2'd0, 1'b0, "R1 ");

        // program one data and one instruction entry
        put(1'b0, 1'b0, 6'd5, {19'd197, 13'h0001});
        put(1'b0, 1'b1, 6'd5, {19'h41234, 7'd0, 6'b001011});
        put(1'b1, 1'b0, 6'd9, {19'd137, 13'h0001});
        put(1'b1, 1'b1, 6'd9, {19'h20f0f, 7'd0, 6'b000100});

        // R5 supervisor and user data rights
        look(VA_D, 2'd0, 1'b1, "R5 ");
        look(VA_D, 2'd1, 1'b1, "R5 ");
        look(VA_D, 2'd0, 1'b0, "R5 ");
        look(VA_D, 2'd1, 1'b0, "R6 ");
        // R4 execute rights
        look(VA_I, 2'd2, 1'b1, "R4 ");
        look(VA_I, 2'd2, 1'b0, "R6 ");
        // R2 separate tables: fetch of data page misses, load of code page misses
        look(VA_D, 2'd2, 1'b1, "R2 ");
        look(VA_I, 2'd0, 1'b1, "R2 ");
        // R2 tag mismatch at the same set
        look({19'd325, 13'h0abc}, 2'd0, 1'b1, "R2 ");
        // R2 tag matches but valid clear
        put(1'b0, 1'b0, 6'd7, {19'd71, 13'h0000});
        put(1'b0, 1'b1, 6'd7, {19'h00077, 7'd0, 6'b111111});
        look({19'd71, 13'h0005}, 2'd0, 1'b1, "R2 ");

        // R3 write and lookup of the same entry in one cycle
        quiet();
        wr_en_i = 1'b1; wr_itlb_i = 1'b0; wr_xlat_i = 1'b1; wr_idx_i = 6'd5;
        wr_data_i = {19'h41234, 7'd0, 6'b011011};
        lk_valid_i = 1'b1; lk_vaddr_i = VA_D; lk_type_i = 2'd1; sup_mode_i = 1'b0;
        step("R3 ");
        look(VA_D, 2'd1, 1'b0, "R3 ");

        // R10 reservation, then fault in the same cycle as a new request
        quiet(); llres_set_i = 1'b1; llres_addr_i = 32'hcafe_0010; step("R10 ");
        quiet(); step("R10 ");
        quiet(); llres_set_i = 1'b1; llres_addr_i = 32'hbeef_0020;
        lk_valid_i = 1'b1; lk_vaddr_i = VA_I; lk_type_i = 2'd2; sup_mode_i = 1'b0;
        step("R10 ");
        quiet(); step("R9 ");
        // R8 no exception when the valid input is low
        quiet(); lk_vaddr_i = 32'h7777_0000; lk_type_i = 2'd0; step("R8 ");
        quiet(); step("R8 ");

        // R12 debug fallback order
        quiet(); sup_mode_i = 1'b1; dbg_vaddr_i = VA_D; step("R12 ");
        dbg_vaddr_i = VA_I; step("R12 ");
        sup_mode_i = 1'b0; step("R12 ");
        dbg_vaddr_i = 32'h0f0f_1234; step("R12 ");

        // R11 identity when disabled
        mmu_en_i = 1'b0; dbg_vaddr_i = VA_D;
        look(32'h9abc_def0, 2'd1, 1'b0, "R11 ");
        look(VA_I, 2'd2, 1'b0, "R11 ");
        quiet(); step("R11 ");
        mmu_en_i = 1'b1;

        // random mix over a few sets and two tags per set
        for (int n = 0; n < 3000; n++) begin
            wr_en_i    = ($urandom % 4) == 0;
            wr_itlb_i  = 1'($urandom);
            wr_xlat_i  = 1'($urandom);
            wr_idx_i   = 6'($urandom % 4);
            vp         = 19'((($urandom % 2) << 6) | ($urandom % 4));
            wr_data_i  = {vp, 7'($urandom), 6'($urandom) | 6'(wr_xlat_i ? 0 : ($urandom % 4 != 0))};
            lk_valid_i = 1'($urandom);
            vp         = 19'((($urandom % 2) << 6) | ($urandom % 4));
            lk_vaddr_i = {vp, 13'($urandom)};
            lk_type_i  = 2'($urandom % 3);
            sup_mode_i = 1'($urandom);
            mmu_en_i   = ($urandom % 10) != 0;
            llres_set_i  = ($urandom % 4) == 0;
            llres_addr_i = $urandom;
            vp          = 19'((($urandom % 2) << 6) | ($urandom % 4));
            dbg_vaddr_i = {vp, 13'($urandom)};
            step("");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule